// File: doc/BRIEF.md
# Decimal-Capable Accumulator Add/Subtract Unit

This block is the arithmetic core of an accumulator-style processor for the add-with-carry and subtract-with-borrow operations. It combines the accumulator with a memory operand and the incoming carry flag. It produces a new accumulator value and the negative, overflow, zero and carry flags. A width select picks between byte operation on the low half of the accumulator and full-word operation. A decimal select picks between plain two's-complement arithmetic and packed-decimal arithmetic. In packed-decimal mode every 4-bit nibble is one digit, and a ripple correction runs from the lowest digit upward.

The arithmetic itself is combinational. A single register stage captures the new accumulator and the four flags on the clock edge where a start strobe is high. A valid pulse follows one cycle later, and the stored values are held until the next start. In byte mode the upper half of the accumulator passes through unchanged, and the upper half of the operand plays no part. Operand fetch, addressing and instruction decode belong to the surrounding processor.

Top module: `dec_addsub_unit`

## Requirements
- R1: With do_sub=0 and dec_mode=0 the result is acc + opnd + carry_in at the active width (8 bits when byte_mode=1, 16 bits when byte_mode=0), and flag_c is 1 exactly when that sum reaches 2^width.
- R2: With do_sub=1 and dec_mode=0 the result is acc - opnd - (1 - carry_in) modulo 2^width, and flag_c is 1 exactly when that difference is not negative (no borrow).
- R3: With do_sub=0 and dec_mode=1, each 4-bit digit is processed from least significant upward as a + m + carry. The carry into the lowest digit is carry_in. A digit total above 9 is reduced by 10, truncated to 4 bits, and carries 1 into the next digit. flag_c is the carry out of the top active digit.
- R4: With do_sub=1 and dec_mode=1, each digit is processed from least significant upward as a - m - borrow. The borrow into the lowest digit is 1 - carry_in. A digit value outside 0..9 (negative, or above 9) gets 10 added, is truncated to 4 bits, and borrows 1 from the next digit. flag_c is 1 when the top active digit does not borrow.
- R5: For addition (both modes), flag_v is 1 when acc and opnd have equal sign bits and the result's sign bit differs from the opnd sign bit. The sign bit is bit 7 in byte mode and bit 15 in word mode.
- R6: For subtraction (both modes), flag_v is 1 when acc and opnd have different sign bits and the result's sign bit differs from the acc sign bit.
- R7: flag_n equals the sign bit of the result at the active width, and flag_z is 1 exactly when the result at the active width is all zeros.
- R8: In byte mode (byte_mode=1), res_acc[15:8] equals acc_in[15:8], opnd_in[15:8] has no effect on any output, and all flags come from the low byte only.
- R9: When start=1 at a clock edge, res_acc and the flags take the computed values at that edge and res_valid is 1 for the following cycle. Without start, res_valid is 0 and res_acc and the flags keep their values.
- R10: A synchronous active-high reset clears res_acc, all four flags and res_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for the computed result |
| do_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| byte_mode | input | 1 | 1 = 8-bit operation on the low half, 0 = full word |
| dec_mode | input | 1 | 1 = packed-decimal digits, 0 = binary |
| carry_in | input | 1 | Incoming carry flag (for subtraction, 1 means no borrow) |
| acc_in | input | WORD_W | Current accumulator |
| opnd_in | input | WORD_W | Memory operand |
| res_acc | output | WORD_W | Registered new accumulator |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| res_valid | output | 1 | High for one cycle after a start |

## Verification
The bench builds the unit with the default WORD_W of 16, which gives four decimal digits in word mode and two in byte mode. Both widths are therefore reachable through the width select, and the byte-mode carry is tapped from the middle of the same digit chain. At this size every valid two-digit packed-decimal pair can be swept in byte mode, for both carry states and both directions. Random vectors cover binary, word-mode decimal and invalid-digit inputs. Directed cases cover carry and borrow across all digits and the sign-overflow boundaries.

// File: rtl/bcdu_pkg.sv
package bcdu_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DEC_RADIX = 10;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } bcdu_flags_t;
endpackage

// File: rtl/bcdu_digit_cell.sv
module bcdu_digit_cell
  import bcdu_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] m_dig,
  input  logic               sub,
  input  logic               link_in,
  output logic [DIGIT_W-1:0] r_dig,
  output logic               link_out
);
  localparam int TW = DIGIT_W + 2;

  logic [TW-1:0] raw;
  logic [TW-1:0] fixed;

  // one window serves both directions: a negative difference wraps to a
  // large unsigned value, so "above 9" catches both overflow and borrow
  always_comb begin
    if (sub)
      raw = {2'b00, a_dig} - {2'b00, m_dig} - {{(TW-1){1'b0}}, link_in};
    else
      raw = {2'b00, a_dig} + {2'b00, m_dig} + {{(TW-1){1'b0}}, link_in};
    link_out = (raw > TW'(DEC_RADIX - 1));
    if (!link_out)
      fixed = raw;
    else if (sub)
      fixed = raw + TW'(DEC_RADIX);
    else
      fixed = raw - TW'(DEC_RADIX);
    r_dig = fixed[DIGIT_W-1:0];
  end

  always_comb begin
    if ((a_dig <= DIGIT_W'(DEC_RADIX - 1)) && (m_dig <= DIGIT_W'(DEC_RADIX - 1)))
      AST_DIGIT_IN_RANGE: assert (r_dig <= DIGIT_W'(DEC_RADIX - 1)); // R3
  end
endmodule

// File: rtl/bcdu_digit_chain.sv
module bcdu_digit_chain
  import bcdu_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [NDIG*DIGIT_W-1:0] a_in,
  input  logic [NDIG*DIGIT_W-1:0] m_in,
  input  logic                    sub,
  input  logic                    carry_in,
  output logic [NDIG*DIGIT_W-1:0] r_out,
  output logic                    link_half,
  output logic                    link_full
);
  localparam int HALF_DIG = NDIG / 2;

  logic [NDIG:0] link;

  // for subtraction the chain carries a borrow, the inverse of the flag
  assign link[0] = sub ? ~carry_in : carry_in;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    bcdu_digit_cell u_cell (
      .a_dig   (a_in[d*DIGIT_W +: DIGIT_W]),
      .m_dig   (m_in[d*DIGIT_W +: DIGIT_W]),
      .sub     (sub),
      .link_in (link[d]),
      .r_dig   (r_out[d*DIGIT_W +: DIGIT_W]),
      .link_out(link[d+1])
    );
  end

  assign link_half = link[HALF_DIG];
  assign link_full = link[NDIG];
endmodule

// File: rtl/bcdu_bin_adder.sv
module bcdu_bin_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  input  logic         sub,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_half,
  output logic         carry_full
);
  localparam int H = W / 2;

  logic [W-1:0] m_eff;
  logic [H:0]   lo;
  logic [H:0]   hi;

  // a - m - (1 - c) == a + ~m + c ; carry out then means "no borrow"
  always_comb begin
    m_eff = sub ? ~m_in : m_in;
    lo = {1'b0, a_in[H-1:0]} + {1'b0, m_eff[H-1:0]} + {{H{1'b0}}, carry_in};
    hi = {1'b0, a_in[W-1:H]} + {1'b0, m_eff[W-1:H]} + {{H{1'b0}}, lo[H]};
    sum        = {hi[H-1:0], lo[H-1:0]};
    carry_half = lo[H];
    carry_full = hi[H];
  end
endmodule

// File: rtl/bcdu_flag_gen.sv
module bcdu_flag_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] r_in,
  input  logic         a_sign,
  input  logic         m_sign,
  input  logic         sub,
  input  logic         narrow,
  output logic         neg,
  output logic         ovf,
  output logic         zero
);
  localparam int H = W / 2;

  logic r_sign;

  always_comb begin
    r_sign = narrow ? r_in[H-1] : r_in[W-1];
    neg    = r_sign;
    zero   = narrow ? (r_in[H-1:0] == '0) : (r_in == '0);
    if (sub)
      ovf = (a_sign ^ m_sign) & (a_sign ^ r_sign);
    else
      ovf = ~(a_sign ^ m_sign) & (m_sign ^ r_sign);
  end
endmodule

// File: rtl/dec_addsub_unit.sv
module dec_addsub_unit
  import bcdu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              do_sub,
  input  logic              byte_mode,
  input  logic              dec_mode,
  input  logic              carry_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] opnd_in,
  output logic [WORD_W-1:0] res_acc,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c,
  output logic              res_valid
);
  localparam int HALF_W = WORD_W / 2;
  localparam int NDIG   = WORD_W / DIGIT_W;

  logic [WORD_W-1:0] bin_sum, dec_sum, sel_sum, acc_next;
  logic              bin_c_half, bin_c_full;
  logic              dec_l_half, dec_l_full;
  logic              dec_link, carry_next;
  logic              a_sign, m_sign;
  logic              n_next, v_next, z_next;
  bcdu_flags_t       flags_q;

  bcdu_bin_adder #(.W(WORD_W)) u_bin (
    .a_in      (acc_in),
    .m_in      (opnd_in),
    .sub       (do_sub),
    .carry_in  (carry_in),
    .sum       (bin_sum),
    .carry_half(bin_c_half),
    .carry_full(bin_c_full)
  );

  bcdu_digit_chain #(.NDIG(NDIG)) u_dec (
    .a_in     (acc_in),
    .m_in     (opnd_in),
    .sub      (do_sub),
    .carry_in (carry_in),
    .r_out    (dec_sum),
    .link_half(dec_l_half),
    .link_full(dec_l_full)
  );

  always_comb begin
    sel_sum  = dec_mode ? dec_sum : bin_sum;
    dec_link = byte_mode ? dec_l_half : dec_l_full;
    if (dec_mode)
      carry_next = do_sub ? ~dec_link : dec_link;
    else
      carry_next = byte_mode ? bin_c_half : bin_c_full;
    acc_next = byte_mode ? {acc_in[WORD_W-1:HALF_W], sel_sum[HALF_W-1:0]} : sel_sum;
    a_sign   = byte_mode ? acc_in[HALF_W-1]  : acc_in[WORD_W-1];
    m_sign   = byte_mode ? opnd_in[HALF_W-1] : opnd_in[WORD_W-1];
  end

  bcdu_flag_gen #(.W(WORD_W)) u_flags (
    .r_in  (sel_sum),
    .a_sign(a_sign),
    .m_sign(m_sign),
    .sub   (do_sub),
    .narrow(byte_mode),
    .neg   (n_next),
    .ovf   (v_next),
    .zero  (z_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_acc   <= '0;
      flags_q   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_acc       <= acc_next;
        flags_q.neg   <= n_next;
        flags_q.ovf   <= v_next;
        flags_q.zero  <= z_next;
        flags_q.carry <= carry_next;
      end
    end
  end

  assign flag_n = flags_q.neg;
  assign flag_v = flags_q.ovf;
  assign flag_z = flags_q.zero;
  assign flag_c = flags_q.carry;

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid); // R9
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(res_acc) && $stable(flags_q))); // R9
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (start && byte_mode) |=> (res_acc[WORD_W-1:HALF_W] == $past(acc_in[WORD_W-1:HALF_W]))); // R8
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    (start && !byte_mode) |=> (flag_z == (res_acc == '0))); // R7
endmodule

// File: tb/dec_addsub_unit_bench.sv
`timescale 1ns/1ps
module dec_addsub_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        do_sub = 1'b0, byte_mode = 1'b0, dec_mode = 1'b0, carry_in = 1'b0;
  logic [15:0] acc_in = '0, opnd_in = '0;
  logic [15:0] res_acc;
  logic        flag_n, flag_v, flag_z, flag_c, res_valid;
  int          tests = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  dec_addsub_unit u_dec_addsub_unit (
    .clk(clk), .rst(rst), .start(start), .do_sub(do_sub), .byte_mode(byte_mode),
    .dec_mode(dec_mode), .carry_in(carry_in), .acc_in(acc_in), .opnd_in(opnd_in),
    .res_acc(res_acc), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .res_valid(res_valid)
  );

  // packed result: {acc[15:0], n, v, z, c}
  function automatic logic [19:0] model(input logic s, input logic nb, input logic dm,
                                        input logic [15:0] a, input logic [15:0] m,
                                        input logic c);
    int w    = nb ? 8 : 16;
    int mask = (1 << w) - 1;
    int ai   = int'(a) & mask;
    int mi   = int'(m) & mask;
    int r    = 0;
    int cout = 0;
    int link;
    logic sa, sm, sr;
    logic [15:0] full;
    if (!dm) begin
      int t = s ? (ai - mi - (1 - int'(c))) : (ai + mi + int'(c));
      cout = s ? int'(t >= 0) : ((t >> w) & 1);
      r = t & mask;
    end else begin
      link = s ? 1 - int'(c) : int'(c);
      for (int i = 0; i < w / 4; i++) begin
        int d = s ? (((ai >> (4*i)) & 15) - ((mi >> (4*i)) & 15) - link)
                  : (((ai >> (4*i)) & 15) + ((mi >> (4*i)) & 15) + link);
        if (d < 0 || d > 9) begin
          d = s ? d + 10 : d - 10;
          link = 1;
        end else link = 0;
        r = r | ((d & 15) << (4*i));
      end
      cout = s ? 1 - link : link;
    end
    sa = ai[w-1]; sm = mi[w-1]; sr = r[w-1];
    full = nb ? {a[15:8], r[7:0]} : r[15:0];
    model = {full, sr,
             s ? ((sa != sm) && (sr != sa)) : ((sa == sm) && (sr != sm)),
             r == 0, cout[0]};
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; result sampled one falling edge later
  task automatic run_op(input string tag, input logic s, input logic nb, input logic dm,
                        input logic [15:0] a, input logic [15:0] m, input logic c);
    do_sub = s; byte_mode = nb; dec_mode = dm; acc_in = a; opnd_in = m; carry_in = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tag, {res_acc, flag_n, flag_v, flag_z, flag_c}, model(s, nb, dm, a, m, c));
    if (res_valid !== 1'b1) check("R9 valid", 20'(res_valid), 20'd1);
  endtask

  function automatic string tag_of(input logic s, input logic dm);
    if (dm) return s ? "R4" : "R3";
    return s ? "R2" : "R1";
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] snap, alt;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R10 reset", {res_acc, flag_n, flag_v, flag_z, flag_c}, 20'h0);
    check("R10 reset valid", 20'(res_valid), 20'h0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_op("R1 byte carry/zero", 0, 1, 0, 16'h12FF, 16'h0001, 0);
    run_op("R5 byte add ovf",    0, 1, 0, 16'h007F, 16'h0001, 0);
    run_op("R2 byte borrow",     1, 1, 0, 16'h0000, 16'h0001, 1);
    run_op("R6 byte sub ovf",    1, 1, 0, 16'h0080, 16'h0001, 1);
    run_op("R1 word carry",      0, 0, 0, 16'hFFFF, 16'h0000, 1);
    run_op("R6 word sub ovf",    1, 0, 0, 16'h8000, 16'h0001, 1);
    run_op("R3 word dec carry",  0, 0, 1, 16'h9999, 16'h0001, 0);
    run_op("R4 word dec borrow", 1, 0, 1, 16'h0000, 16'h0001, 1);
    run_op("R3 invalid digits",  0, 1, 1, 16'h00FF, 16'h00FF, 1);
    run_op("R4 invalid digits",  1, 1, 1, 16'h00FA, 16'h000C, 0);
    run_op("R7 dec zero",        1, 1, 1, 16'h0050, 16'h0050, 1);
    run_op("R5 dec add ovf",     0, 1, 1, 16'h0079, 16'h0001, 0);

    // R8: upper operand byte must not influence any output
    run_op("R8 upper opnd A", 0, 1, 1, 16'hAB45, 16'h0037, 1);
    alt = model(0, 1, 1, 16'hAB45, 16'h0037, 1);
    run_op("R8 upper opnd B", 0, 1, 1, 16'hAB45, 16'hFF37, 1);
    check("R8 same result", {res_acc, flag_n, flag_v, flag_z, flag_c}, alt);

    // R9: hold without start
    snap = {res_acc, flag_n, flag_v, flag_z, flag_c};
    acc_in = 16'h1111; opnd_in = 16'h2222;
    @(negedge clk);
    check("R9 hold", {res_acc, flag_n, flag_v, flag_z, flag_c}, snap);
    check("R9 valid low", 20'(res_valid), 20'h0);

    // random mixed vectors
    for (int i = 0; i < 3000; i++) begin
      logic s  = 1'($urandom);
      logic nb = 1'($urandom);
      logic dm = 1'($urandom);
      run_op(tag_of(s, dm), s, nb, dm, 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // every valid two-digit decimal pair, both carries, both directions
    for (int a = 0; a < 100; a++) begin
      for (int m = 0; m < 100; m++) begin
        for (int k = 0; k < 4; k++) begin
          logic [15:0] ab = {8'h5A, 4'(a / 10), 4'(a % 10)};
          logic [15:0] mb = {8'hC3, 4'(m / 10), 4'(m % 10)};
          run_op(k[1] ? "R4" : "R3", k[1], 1, 1, ab, mb, k[0]);
        end
      end
    end

    // R10: reset during operation
    run_op("R1 pre-reset", 0, 0, 0, 16'h1234, 16'h1111, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid reset", {res_acc, flag_n, flag_v, flag_z, flag_c}, 20'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule